// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame by reading a two-level page table in memory. A caller gives it a virtual address and the byte address of the top-level table that belongs to the current address space. The block splits the address into two 10-bit table indices and a 12-bit page offset. It reads the top-level entry. If that entry is valid, the entry points at a second-level table, and the block reads the second-level entry from it. When that entry is also valid, the block returns its frame number, its permission bits and the physical address it forms.

If either entry has its valid bit clear, the walk stops and reports a page fault that names the failing level. Reads go out over a plain request/response port. A request is held until it is accepted. The response can come back after any number of idle cycles.

The block runs only one walk at a time. A busy flag stays high from acceptance through the one-cycle completion or fault pulse. While that flag is high, any new walk request is dropped.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_rd_valid` are all low.
- R2: The first read goes to `req_root + 4*va[31:22]`. The block keeps `mem_rd_valid` high and `mem_rd_addr` unchanged until a cycle in which `mem_rd_ready` is high.
- R3: When the top-level entry is valid, the second read goes to `{entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: Bit 0 of an entry is its valid bit. An invalid top-level entry ends the walk with `fault` high and `fault_lvl` = 0, and no second read is issued.
- R5: An invalid second-level entry ends the walk with `fault` high and `fault_lvl` = 1.
- R6: A valid second-level entry ends the walk with `done` high. At that point `res_pfn` = entry[31:12], `res_perm` = entry[11:1] and `res_paddr` = {entry[31:12], va[11:0]}.
- R7: `done` and `fault` are never high together, and each lasts exactly one cycle. `busy` rises in the cycle after a request is accepted, stays high through the pulse cycle, and is low in the cycle after the pulse.
- R8: A request presented while `busy` is high is ignored. This includes a request in the pulse cycle itself: it neither starts a walk nor changes the running walk's result.
- R9: A response is taken only while its read is outstanding. A `mem_rsp_valid` pulse in the idle state, or while a read request is still waiting for `mem_rd_ready`, has no effect. Any response latency works.
- R10: At most one read is outstanding. `mem_rd_valid` stays low from an accepted read until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle successful completion |
| fault | output | 1 | One-cycle page fault |
| fault_lvl | output | 1 | Failing level: 0 top, 1 second |
| res_pfn | output | 20 | Physical frame number |
| res_perm | output | 11 | Permission bits of the leaf entry |
| res_paddr | output | 32 | Frame number joined with the page offset |

## Verification
Two things can land on the same clock edge: the one-cycle completion pulse and a new walk request. The bench holds `req_valid` high with a different address for the whole walk, including the pulse cycle. It then checks three things: the result belongs to the original address, `busy` is low one cycle later, and no read starts afterwards. The second overlap is a memory response arriving while a read request is still stalled on `mem_rd_ready`. The bench drives an invalid entry on the response lines during those stall cycles. It then requires the request to stay posted and the walk to finish normally.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD1   = 3'd1,
    ST_WT1   = 3'd2,
    ST_RD2   = 3'd3,
    ST_WT2   = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walk_st_t;

  // position of the valid flag inside a table entry
  localparam int unsigned PTE_VLD_BIT = 0;

  // fault level codes
  localparam logic LVL_TOP = 1'b0;
  localparam logic LVL_SUB = 1'b1;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_pte_vld,
  output logic busy,
  output logic mem_rd_valid,
  output logic use_lvl2,
  output logic cap_req,
  output logic cap_l1,
  output logic cap_l2,
  output logic done,
  output logic fault,
  output logic fault_lvl
);

  walk_st_t st_q, st_d;
  logic     lvl_q, lvl_d, lvl_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cap_req = 1'b0;
    cap_l1  = 1'b0;
    cap_l2  = 1'b0;
    lvl_en  = 1'b0;
    lvl_d   = lvl_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          st_d    = ST_RD1;
        end
      end
      ST_RD1: begin
        if (mem_rd_ready) st_d = ST_WT1;
      end
      ST_WT1: begin
        if (mem_rsp_valid) begin
          if (rsp_pte_vld) begin
            cap_l1 = 1'b1;
            st_d   = ST_RD2;
          end else begin
            lvl_en = 1'b1;
            lvl_d  = LVL_TOP;
            st_d   = ST_FAULT;
          end
        end
      end
      ST_RD2: begin
        if (mem_rd_ready) st_d = ST_WT2;
      end
      ST_WT2: begin
        if (mem_rsp_valid) begin
          if (rsp_pte_vld) begin
            cap_l2 = 1'b1;
            st_d   = ST_DONE;
          end else begin
            lvl_en = 1'b1;
            lvl_d  = LVL_SUB;
            st_d   = ST_FAULT;
          end
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // fault level register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_TOP;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  // state-decoded outputs
  always_comb begin
    busy         = (st_q != ST_IDLE);
    mem_rd_valid = (st_q == ST_RD1) || (st_q == ST_RD2);
    use_lvl2     = (st_q == ST_RD2);
    done         = (st_q == ST_DONE);
    fault        = (st_q == ST_FAULT);
    fault_lvl    = lvl_q;
  end

endmodule

// File: rtl/pgwalk_regs.sv
module pgwalk_regs #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PFN_W  = PTE_W - OFF_W,
  localparam int unsigned PERM_W = OFF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              cap_l1,
  input  logic              cap_l2,
  input  logic [VA_W-1:0]   in_vaddr,
  input  logic [PTE_W-1:0]  in_root,
  input  logic [PTE_W-1:0]  rsp_data,
  output logic [VA_W-1:0]   va_q,
  output logic [PTE_W-1:0]  root_q,
  output logic [PFN_W-1:0]  tbl_q,
  output logic [PFN_W-1:0]  pfn_q,
  output logic [PERM_W-1:0] perm_q
);

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (cap_req) begin
      va_q   <= in_vaddr;
      root_q <= in_root;
    end
  end

  // second-level table base from the top-level entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (cap_l1) begin
      tbl_q <= rsp_data[PTE_W-1:OFF_W];
    end
  end

  // leaf result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfn_q  <= '0;
      perm_q <= '0;
    end else if (cap_l2) begin
      pfn_q  <= rsp_data[PTE_W-1:OFF_W];
      perm_q <= rsp_data[OFF_W-1:1];
    end
  end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned PTE_W = 32,
  localparam int unsigned OFF_W = VA_W - L1_W - L2_W,
  localparam int unsigned PFN_W = PTE_W - OFF_W,
  localparam int unsigned ESH   = $clog2(PTE_W / 8)
) (
  input  logic [VA_W-1:0]  va_q,
  input  logic [PTE_W-1:0] root_q,
  input  logic [PFN_W-1:0] tbl_q,
  input  logic             use_lvl2,
  output logic [PTE_W-1:0] rd_addr
);

  logic [L1_W-1:0]  idx_top;
  logic [L2_W-1:0]  idx_sub;
  logic [PTE_W-1:0] off_top, off_sub;
  logic [PTE_W-1:0] addr_top, addr_sub;

  always_comb begin
    idx_top  = va_q[VA_W-1 -: L1_W];
    idx_sub  = va_q[OFF_W +: L2_W];
    off_top  = PTE_W'(idx_top) << ESH;
    off_sub  = PTE_W'(idx_sub) << ESH;
    addr_top = root_q + off_top;
    addr_sub = {tbl_q, {OFF_W{1'b0}}} + off_sub;
    rd_addr  = use_lvl2 ? addr_sub : addr_top;
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned PTE_W = 32,
  localparam int unsigned OFF_W  = VA_W - L1_W - L2_W,
  localparam int unsigned PFN_W  = PTE_W - OFF_W,
  localparam int unsigned PERM_W = OFF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PTE_W-1:0]  req_root,
  output logic              busy,
  output logic              mem_rd_valid,
  output logic [PTE_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic              fault_lvl,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  output logic [PTE_W-1:0]  res_paddr
);

  logic              use_lvl2, cap_req, cap_l1, cap_l2;
  logic [VA_W-1:0]   va_q;
  logic [PTE_W-1:0]  root_q;
  logic [PFN_W-1:0]  tbl_q;

  pgwalk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_pte_vld   (mem_rsp_data[pgwalk_pkg::PTE_VLD_BIT]),
    .busy          (busy),
    .mem_rd_valid  (mem_rd_valid),
    .use_lvl2      (use_lvl2),
    .cap_req       (cap_req),
    .cap_l1        (cap_l1),
    .cap_l2        (cap_l2),
    .done          (done),
    .fault         (fault),
    .fault_lvl     (fault_lvl)
  );

  pgwalk_regs #(.VA_W(VA_W), .PTE_W(PTE_W), .OFF_W(OFF_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_req  (cap_req),
    .cap_l1   (cap_l1),
    .cap_l2   (cap_l2),
    .in_vaddr (req_vaddr),
    .in_root  (req_root),
    .rsp_data (mem_rsp_data),
    .va_q     (va_q),
    .root_q   (root_q),
    .tbl_q    (tbl_q),
    .pfn_q    (res_pfn),
    .perm_q   (res_perm)
  );

  pgwalk_addr #(.VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .PTE_W(PTE_W)) u_addr (
    .va_q     (va_q),
    .root_q   (root_q),
    .tbl_q    (tbl_q),
    .use_lvl2 (use_lvl2),
    .rd_addr  (mem_rd_addr)
  );

  assign res_paddr = {res_pfn, va_q[OFF_W-1:0]};

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PTE_W-1:0] mem_rd_addr,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic             fault,
  input logic             fault_lvl
);

  logic [1:0] rd_cnt;
  logic       pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= 2'd0;
      pend   <= 1'b0;
    end else begin
      if (req_valid && !busy) rd_cnt <= 2'd0;
      else if (mem_rd_valid && mem_rd_ready) rd_cnt <= rd_cnt + 2'd1;
      if (mem_rd_valid && mem_rd_ready) pend <= 1'b1;
      else if (mem_rsp_valid) pend <= 1'b0;
    end
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R4
  top_fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_lvl) |-> (rd_cnt == 2'd1));

  // R5
  sub_fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_lvl) |-> (rd_cnt == 2'd2));

  // R6
  done_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_cnt == 2'd2));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  // R7
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (busy && !done && !fault));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mem_rd_valid);

endmodule

bind pgwalk_top pgwalk_chk #(.PTE_W(PTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .fault_lvl     (fault_lvl)
);

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr, req_root;
  logic        busy, mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;
  logic        done, fault, fault_lvl;
  logic [19:0] res_pfn;
  logic [10:0] res_perm;
  logic [31:0] res_paddr;

  logic        req_drv, spam_on;
  logic [31:0] va_drv, root_drv;

  logic [31:0] mem [logic [31:0]];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  assign req_valid = req_drv | spam_on;
  assign req_vaddr = spam_on ? 32'hFFFF_F000 : va_drv;
  assign req_root  = spam_on ? 32'h0009_0000 : root_drv;

  pgwalk_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_root(req_root), .busy(busy), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .fault(fault), .fault_lvl(fault_lvl), .res_pfn(res_pfn),
    .res_perm(res_perm), .res_paddr(res_paddr)
  );

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      report();
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic service_read(input logic [31:0] exp_a, input int stall,
                              input int lat, input bit junk, input string tag);
    int n = 0;
    while (!mem_rd_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(mem_rd_valid && mem_rd_addr == exp_a, tag, mem_rd_addr, exp_a);
    for (int i = 0; i < stall; i++) begin
      if (junk) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h0;
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      // R2 held while stalled; R9 junk response not taken
      chk(mem_rd_valid && mem_rd_addr == exp_a, {tag, " R2 R9 held"}, mem_rd_addr, exp_a);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk(!mem_rd_valid, "R10 no request while waiting", {31'b0, mem_rd_valid}, 32'h0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = rd(exp_a);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [31:0] root,
                         input int s1, input int l1, input int s2, input int l2,
                         input bit junk, input bit hold);
    logic [31:0] a1, a2, e1, e2;
    int extra = 0;
    int n = 0;
    a1 = root + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    e2 = rd(a2);
    req_drv = 1'b1; va_drv = va; root_drv = root;
    @(negedge clk);
    req_drv = 1'b0;
    if (hold) spam_on = 1'b1;
    chk(busy, "R7 busy after accept", {31'b0, busy}, 32'h1);
    service_read(a1, s1, l1, junk, "R2 top-level entry address");
    if (e1[0]) service_read(a2, s2, l2, junk, "R3 second-level entry address");
    while (!(done || fault) && n < 40) begin
      @(negedge clk);
      if (mem_rd_valid) extra++;
      n++;
    end
    chk(extra == 0, "R4 R10 no extra read", extra, 0);
    if (!e1[0]) begin
      chk(fault && !done && fault_lvl == 1'b0, "R4 top-level fault",
          {29'b0, done, fault, fault_lvl}, 32'h2);
    end else if (!e2[0]) begin
      chk(fault && !done && fault_lvl == 1'b1, "R5 second-level fault",
          {29'b0, done, fault, fault_lvl}, 32'h3);
    end else begin
      chk(done && !fault, "R6 done pulse", {30'b0, done, fault}, 32'h2);
      chk(res_pfn == e2[31:12], "R6 frame number", {12'b0, res_pfn}, {12'b0, e2[31:12]});
      chk(res_perm == e2[11:1], "R6 permissions", {21'b0, res_perm}, {21'b0, e2[11:1]});
      chk(res_paddr == {e2[31:12], va[11:0]}, "R6 physical address",
          res_paddr, {e2[31:12], va[11:0]});
    end
    chk(busy, "R7 busy in pulse cycle", {31'b0, busy}, 32'h1);
    @(negedge clk);
    spam_on = 1'b0;
    chk(!done && !fault, "R7 single-cycle pulse", {30'b0, done, fault}, 32'h0);
    chk(!busy, "R7 R8 busy released", {31'b0, busy}, 32'h0);
    if (hold) begin
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk(!busy && !mem_rd_valid, "R8 request in busy window dropped",
            {30'b0, busy, mem_rd_valid}, 32'h0);
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fault && !mem_rd_valid, "R1 reset state",
        {28'b0, busy, done, fault, mem_rd_valid}, 32'h0);
  endtask

  task automatic t_basic();
    do_walk(32'h1234_5678, 32'h0001_0000, 0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_edge_latency();
    // max indices, stalls with junk responses and long latency
    do_walk(32'hFFFF_FFFF, 32'h0001_0000, 3, 5, 2, 7, 1'b1, 1'b0);
  endtask

  task automatic t_top_fault();
    do_walk(32'h0000_0000, 32'h0001_0000, 1, 2, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_sub_fault();
    do_walk(32'h0040_1000, 32'h0001_0000, 0, 3, 1, 1, 1'b0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    do_walk(32'h1234_5678, 32'h0001_0000, 2, 1, 0, 2, 1'b0, 1'b1);
  endtask

  task automatic t_idle_rsp();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h0002_0001;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(!busy && !mem_rd_valid && !done && !fault, "R9 idle response ignored",
        {28'b0, busy, mem_rd_valid, done, fault}, 32'h0);
  endtask

  task automatic t_back_to_back();
    do_walk(32'h1234_5678, 32'h0008_0000, 0, 0, 0, 0, 1'b0, 1'b0);
    do_walk(32'h0040_1000, 32'h0001_0000, 0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req_drv = 1'b0; spam_on = 1'b0;
    va_drv = '0; root_drv = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    mem[32'h0001_0120] = 32'h0002_0001;
    mem[32'h0002_0D14] = 32'hABCD_E00F;
    mem[32'h0001_0FFC] = 32'h0003_0001;
    mem[32'h0003_0FFC] = 32'h1234_5FFF;
    mem[32'h0001_0004] = 32'h0004_0001;
    mem[32'h0004_0004] = 32'h5555_5FFE;
    mem[32'h0008_0120] = 32'h0005_0001;
    mem[32'h0005_0D14] = 32'h0007_7003;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_edge_latency();
    t_top_fault();
    t_sub_fault();
    t_busy_ignore();
    t_idle_rsp();
    t_back_to_back();
    repeat (2) @(negedge clk);
    report();
  end

endmodule